// File: doc/BRIEF.md
# Transaction ordering queue scheduler

This block sits on one direction of a switch port. It takes transaction headers one at a time and places each into one of three queues by transaction kind. Memory writes and messages go to the posted queue. Read requests and non-posted write requests go to the non-posted queue. Read completions and non-posted write completions go to the completion queue. Each cycle the block offers at most one header on a valid/ready egress handshake. It picks that header so that producer-consumer ordering holds inside each traffic class and no queue can be starved into a deadlock.

Whether one header may overtake another depends on both of their kinds, on their traffic classes and on the relaxed-ordering bit of the header that would overtake. Posted traffic may always go ahead of the other two queues. Requests and strict-order completions wait until every older posted header of their own traffic class has left. A two-way fairness toggle shares the egress between the posted queue and the combined non-posted and completion side. Payload data, credits and link handling belong to other blocks.

Top module: `tord_sched`

## Requirements
- R1: After reset, out_valid is low and in_ready is high. out_valid is never high unless at least one header is held.
- R2: Kind codes on in_kind are: 0 memory write, 1 message, 2 read request, 3 non-posted write request, 4 read completion, 5 non-posted write completion. Codes 6 and 7 are handled like code 4. Codes 0 and 1 go to the posted queue, 2 and 3 to the non-posted queue, and 4 to 7 to the completion queue. Within the non-posted queue and within the completion queue, headers leave in arrival order.
- R3: Posted headers leave in arrival order whatever their relaxed-ordering bit (in_ro) is.
- R4: A non-posted header never leaves before an older posted header of the same traffic class.
- R5: A read completion with in_ro = 0 never leaves before an older posted header of the same traffic class. With in_ro = 1 it may leave ahead of such a header.
- R6: A non-posted write completion may leave ahead of older posted headers of the same class, whatever its relaxed-ordering bit.
- R7: A posted header is never held back by non-posted or completion headers. While any posted header is held, out_valid is high.
- R8: Headers of different traffic classes place no ordering constraint on each other.
- R9: When the posted head and a header on the other side are both eligible, the grant goes to the side that was not granted last. Between an eligible non-posted head and an eligible completion head, the older one goes first.
- R10: in_ready is low exactly when the queue selected by in_kind holds DEPTH headers. A full queue does not block pushes to the other queues.
- R11: While out_valid is high and out_ready is low, out_valid stays high and the offered header does not change.
- R12: A push and an egress transfer can complete in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Header push request |
| in_ready | output | 1 | Queue selected by in_kind has room |
| in_kind | input | 3 | Transaction kind code (see R2) |
| in_tc | input | TC_W | Traffic class |
| in_ro | input | 1 | Relaxed-ordering attribute |
| in_tag | input | TAG_W | Opaque header identifier carried to egress |
| out_valid | output | 1 | A header is offered |
| out_ready | input | 1 | Egress accepts the offered header |
| out_kind | output | 3 | Kind of offered header |
| out_tc | output | TC_W | Traffic class of offered header |
| out_ro | output | 1 | Relaxed-ordering bit of offered header |
| out_tag | output | TAG_W | Identifier of offered header |

## Verification
The assertions check four things on every cycle. in_ready must match a queue occupancy counted from the ports. An offered header must stay fixed during a stall. Nothing may be offered from an empty store. Any held posted header must keep out_valid high. The actual overtaking decisions, the gating by traffic class and the relaxed-ordering bit, and the alternation of the fairness toggle are only visible in the bench scenarios. There, loaded queues are drained and every overtaking pair in the egress order is judged against the pass rules.

// File: rtl/tord_pkg.sv
// Shared kind codes, queue selector type and the kind-to-queue decode.
// Assumes a 3-bit kind field; codes 6 and 7 are folded into read completions.
package tord_pkg;
    localparam int KIND_W = 3;

    typedef enum logic [KIND_W-1:0] {
        K_MWR  = 3'd0,
        K_MSG  = 3'd1,
        K_RD   = 3'd2,
        K_NPW  = 3'd3,
        K_CPLD = 3'd4,
        K_CPLW = 3'd5
    } kind_e;

    typedef enum logic [1:0] {
        Q_P   = 2'd0,
        Q_NP  = 2'd1,
        Q_CPL = 2'd2
    } qsel_e;

    function automatic qsel_e kind_to_q(input logic [KIND_W-1:0] k);
        if (k == K_MWR || k == K_MSG) return Q_P;
        if (k == K_RD || k == K_NPW) return Q_NP;
        return Q_CPL;
    endfunction
endpackage

// File: rtl/tord_queue.sv
// Circular header FIFO of DEPTH entries, W bits each.
// Assumes the parent never pushes when full and never pops when empty.
// A push and a pop may happen in the same cycle.
module tord_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;

    assign head  = mem[rd_ptr];
    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);

    // Store the pushed header in the slot the write pointer names.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= din;
    end

    // Advance the pointers with wrap, and track the occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/tord_ptrack.sv
// Per-traffic-class posted progress tracker.
// It counts the posted headers pushed and popped in each class. A later
// header keeps a snapshot of its class's push count. That header is blocked
// while the class's pop count has not yet reached the snapshot.
// Assumes a waiting header never falls more than 2^(SNAP_W-1) posted pops
// behind its snapshot.
module tord_ptrack #(
    parameter int TC_W   = 3,
    parameter int SNAP_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_p,
    input  logic [TC_W-1:0]   push_tc,
    input  logic              pop_p,
    input  logic [TC_W-1:0]   pop_tc,
    output logic [SNAP_W-1:0] snap,
    input  logic [TC_W-1:0]   a_tc,
    input  logic [SNAP_W-1:0] a_snap,
    output logic              a_blk,
    input  logic [TC_W-1:0]   b_tc,
    input  logic [SNAP_W-1:0] b_snap,
    output logic              b_blk
);
    localparam int NTC = 1 << TC_W;

    logic [SNAP_W-1:0] pushed [NTC];
    logic [SNAP_W-1:0] popped [NTC];
    logic [SNAP_W-1:0] a_gap, b_gap;

    for (genvar t = 0; t < NTC; t++) begin : g_tc
        // Count the posted headers entering and leaving class t.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pushed[t] <= '0;
                popped[t] <= '0;
            end else begin
                if (push_p && push_tc == TC_W'(t)) pushed[t] <= pushed[t] + 1'b1;
                if (pop_p && pop_tc == TC_W'(t))   popped[t] <= popped[t] + 1'b1;
            end
        end
    end

    // Snapshot for the header being pushed, and the gap left for each probe.
    always_comb begin
        snap  = pushed[push_tc];
        a_gap = a_snap - popped[a_tc];
        b_gap = b_snap - popped[b_tc];
        a_blk = (a_gap != '0) && !a_gap[SNAP_W-1];
        b_blk = (b_gap != '0) && !b_gap[SNAP_W-1];
    end
endmodule

// File: rtl/tord_arb.sv
// Egress picker with posted/other fairness and a hold while stalled.
// Assumes the eligibility of a held selection cannot drop while it is
// stalled. Headers that arrive later are younger and cannot block it.
module tord_arb #(
    parameter int SEQ_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_ok,
    input  logic              np_ok,
    input  logic              cpl_ok,
    input  logic [SEQ_W-1:0]  np_seq,
    input  logic [SEQ_W-1:0]  cpl_seq,
    input  logic              out_ready,
    output logic              valid,
    output tord_pkg::qsel_e   sel
);
    import tord_pkg::*;

    logic       last_p;
    logic       lock;
    qsel_e      lock_sel;
    qsel_e      other_sel;
    logic       other_ok;
    logic [SEQ_W-1:0] age_diff;

    // Choose the other side's head, then apply fairness unless a stall holds the choice.
    always_comb begin
        age_diff = np_seq - cpl_seq;
        other_ok = np_ok || cpl_ok;
        if (np_ok && cpl_ok) other_sel = age_diff[SEQ_W-1] ? Q_NP : Q_CPL;
        else                 other_sel = np_ok ? Q_NP : Q_CPL;
        if (lock) begin
            valid = 1'b1;
            sel   = lock_sel;
        end else begin
            valid = p_ok || other_ok;
            sel   = (p_ok && (!other_ok || !last_p)) ? Q_P : other_sel;
        end
    end

    // Remember a stalled choice and which side was granted last.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_p   <= 1'b0;
            lock     <= 1'b0;
            lock_sel <= Q_P;
        end else begin
            lock     <= valid && !out_ready;
            lock_sel <= sel;
            if (valid && out_ready) last_p <= (sel == Q_P);
        end
    end
endmodule

// File: rtl/tord_sched.sv
// Transaction ordering scheduler for one direction of a switch port.
// Headers are sorted by kind into posted, non-posted and completion queues.
// Each non-posted and completion entry keeps an arrival number and a snapshot
// of posted progress in its traffic class. These decide the pass rules.
// Assumes at most 2^(SEQ_W-1) arrivals separate any two headers that are
// compared by age.
module tord_sched #(
    parameter int DEPTH = 8,
    parameter int TC_W  = 3,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [2:0]       in_kind,
    input  logic [TC_W-1:0]  in_tc,
    input  logic             in_ro,
    input  logic [TAG_W-1:0] in_tag,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [2:0]       out_kind,
    output logic [TC_W-1:0]  out_tc,
    output logic             out_ro,
    output logic [TAG_W-1:0] out_tag
);
    import tord_pkg::*;

    localparam int HDR_W  = KIND_W + TC_W + 1 + TAG_W;
    localparam int SEQ_W  = $clog2(3 * DEPTH) + 3;
    localparam int SNAP_W = $clog2(DEPTH) + 3;
    localparam int ORD_W  = HDR_W + SNAP_W + SEQ_W;
    localparam int TC_LO  = KIND_W;
    localparam int RO_LO  = KIND_W + TC_W;
    localparam int SN_LO  = HDR_W;
    localparam int SQ_LO  = HDR_W + SNAP_W;

    qsel_e             in_q, sel;
    logic              acc;
    logic [HDR_W-1:0]  hdr_in;
    logic [ORD_W-1:0]  ord_in;
    logic [SEQ_W-1:0]  seq_q;
    logic [SNAP_W-1:0] snap;
    logic              p_full, np_full, cpl_full;
    logic              p_empty, np_empty, cpl_empty;
    logic [HDR_W-1:0]  p_head;
    logic [ORD_W-1:0]  np_head, cpl_head;
    logic              np_blk, cpl_blk;
    logic              p_ok, np_ok, cpl_ok;
    logic              fire, pop_p, pop_np, pop_cpl;
    logic [HDR_W-1:0]  out_hdr;

    // Decode the target queue and its room.
    always_comb begin
        in_q   = kind_to_q(in_kind);
        hdr_in = {in_tag, in_ro, in_tc, in_kind};
        unique case (in_q)
            Q_P:     in_ready = !p_full;
            Q_NP:    in_ready = !np_full;
            default: in_ready = !cpl_full;
        endcase
        acc    = in_valid && in_ready;
        ord_in = {seq_q, snap, hdr_in};
    end

    // Number every accepted header in arrival order.
    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '0;
        else if (acc) seq_q <= seq_q + 1'b1;
    end

    tord_queue #(.DEPTH(DEPTH), .W(HDR_W)) u_pq (
        .clk(clk), .rst_n(rst_n),
        .push(acc && in_q == Q_P), .din(hdr_in), .pop(pop_p),
        .head(p_head), .full(p_full), .empty(p_empty)
    );

    tord_queue #(.DEPTH(DEPTH), .W(ORD_W)) u_npq (
        .clk(clk), .rst_n(rst_n),
        .push(acc && in_q == Q_NP), .din(ord_in), .pop(pop_np),
        .head(np_head), .full(np_full), .empty(np_empty)
    );

    tord_queue #(.DEPTH(DEPTH), .W(ORD_W)) u_cq (
        .clk(clk), .rst_n(rst_n),
        .push(acc && in_q == Q_CPL), .din(ord_in), .pop(pop_cpl),
        .head(cpl_head), .full(cpl_full), .empty(cpl_empty)
    );

    tord_ptrack #(.TC_W(TC_W), .SNAP_W(SNAP_W)) u_trk (
        .clk(clk), .rst_n(rst_n),
        .push_p(acc && in_q == Q_P), .push_tc(in_tc),
        .pop_p(pop_p), .pop_tc(p_head[TC_LO +: TC_W]),
        .snap(snap),
        .a_tc(np_head[TC_LO +: TC_W]), .a_snap(np_head[SN_LO +: SNAP_W]), .a_blk(np_blk),
        .b_tc(cpl_head[TC_LO +: TC_W]), .b_snap(cpl_head[SN_LO +: SNAP_W]), .b_blk(cpl_blk)
    );

    // Apply the pass rules to each queue head.
    always_comb begin
        p_ok   = !p_empty;
        np_ok  = !np_empty && !np_blk;
        cpl_ok = !cpl_empty && (cpl_head[KIND_W-1:0] == K_CPLW ||
                                cpl_head[RO_LO] || !cpl_blk);
    end

    tord_arb #(.SEQ_W(SEQ_W)) u_arb (
        .clk(clk), .rst_n(rst_n),
        .p_ok(p_ok), .np_ok(np_ok), .cpl_ok(cpl_ok),
        .np_seq(np_head[SQ_LO +: SEQ_W]), .cpl_seq(cpl_head[SQ_LO +: SEQ_W]),
        .out_ready(out_ready), .valid(out_valid), .sel(sel)
    );

    // Route the selected head to egress and pop it on transfer.
    always_comb begin
        unique case (sel)
            Q_P:     out_hdr = p_head;
            Q_NP:    out_hdr = np_head[HDR_W-1:0];
            default: out_hdr = cpl_head[HDR_W-1:0];
        endcase
        {out_tag, out_ro, out_tc, out_kind} = out_hdr;
        fire    = out_valid && out_ready;
        pop_p   = fire && sel == Q_P;
        pop_np  = fire && sel == Q_NP;
        pop_cpl = fire && sel == Q_CPL;
    end
endmodule

// File: rtl/tord_sched_chk.sv
// Port-level checker for tord_sched. It rebuilds each queue's occupancy
// from the push and egress handshakes and checks the handshake rules.
module tord_sched_chk #(
    parameter int DEPTH = 8,
    parameter int TC_W  = 3,
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [2:0]       in_kind,
    input logic [TC_W-1:0]  in_tc,
    input logic             in_ro,
    input logic [TAG_W-1:0] in_tag,
    input logic             out_valid,
    input logic             out_ready,
    input logic [2:0]       out_kind,
    input logic [TC_W-1:0]  out_tc,
    input logic             out_ro,
    input logic [TAG_W-1:0] out_tag
);
    import tord_pkg::*;
    localparam int CNT_W = $clog2(DEPTH + 1) + 1;

    logic [CNT_W-1:0] occ [3];
    logic [1:0] iq, oq;

    assign iq = 2'(kind_to_q(in_kind));
    assign oq = 2'(kind_to_q(out_kind));

    for (genvar q = 0; q < 3; q++) begin : g_occ
        // Track the occupancy of queue q from the port handshakes.
        always_ff @(posedge clk) begin
            if (!rst_n) occ[q] <= '0;
            else occ[q] <= occ[q]
                         + CNT_W'(in_valid && in_ready && iq == 2'(q))
                         - CNT_W'(out_valid && out_ready && oq == 2'(q));
        end
    end

    a_r10_ready_low_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && occ[iq] == CNT_W'(DEPTH) |-> !in_ready);

    a_r10_ready_when_room: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && occ[iq] < CNT_W'(DEPTH) |-> in_ready);

    a_r11_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid &&
        $stable({out_kind, out_tc, out_ro, out_tag}));

    a_r1_offer_needs_entry: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> occ[oq] != '0);

    a_r7_posted_always_offered: assert property (@(posedge clk) disable iff (!rst_n)
        occ[0] != '0 |-> out_valid);
endmodule

bind tord_sched tord_sched_chk #(.DEPTH(DEPTH), .TC_W(TC_W), .TAG_W(TAG_W)) chk_i (.*);

// File: tb/tord_sched_tb_top.sv
// Bench: a table of push scenarios with their expected egress order, then
// directed tests for reset, a full queue and a same-cycle push and transfer.
module tord_sched_tb_top;
    localparam int TC_W  = 3;
    localparam int TAG_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_ro = 1'b0, out_ready = 1'b0;
    logic [2:0] in_kind = '0;
    logic [TC_W-1:0] in_tc = '0;
    logic [TAG_W-1:0] in_tag = '0;
    logic in_ready, out_valid, out_ro;
    logic [2:0] out_kind;
    logic [TC_W-1:0] out_tc;
    logic [TAG_W-1:0] out_tag;

    always #5 clk = ~clk;

    tord_sched #(.DEPTH(8), .TC_W(TC_W), .TAG_W(TAG_W)) dut_i (.*);

    int errors = 0, checks = 0;
    int arr_no [256];
    int arr_kind [256];
    int arr_tc [256];
    int arr_ro [256];
    int npush = 0;
    int got [64];
    int ngot = 0;

    typedef struct packed {
        logic [3:0] scen;
        logic [2:0] kind;
        logic [2:0] tc;
        logic       ro;
        logic [7:0] tag;
        logic [7:0] exp;
    } row_t;

    localparam int NV = 25;
    localparam row_t TBL [NV] = '{
        '{4'd0, 3'd0, 3'd0, 1'b0, 8'd1,  8'd1},
        '{4'd0, 3'd2, 3'd0, 1'b0, 8'd2,  8'd2},
        '{4'd0, 3'd1, 3'd0, 1'b0, 8'd3,  8'd3},
        '{4'd0, 3'd4, 3'd0, 1'b0, 8'd4,  8'd4},
        '{4'd0, 3'd5, 3'd0, 1'b0, 8'd5,  8'd5},
        '{4'd1, 3'd0, 3'd0, 1'b0, 8'd10, 8'd10},
        '{4'd1, 3'd1, 3'd0, 1'b0, 8'd11, 8'd14},
        '{4'd1, 3'd4, 3'd0, 1'b1, 8'd14, 8'd11},
        '{4'd1, 3'd3, 3'd0, 1'b0, 8'd12, 8'd12},
        '{4'd1, 3'd5, 3'd0, 1'b0, 8'd13, 8'd13},
        '{4'd2, 3'd0, 3'd0, 1'b0, 8'd20, 8'd20},
        '{4'd2, 3'd0, 3'd1, 1'b0, 8'd21, 8'd22},
        '{4'd2, 3'd2, 3'd2, 1'b0, 8'd22, 8'd21},
        '{4'd2, 3'd4, 3'd1, 1'b0, 8'd23, 8'd23},
        '{4'd3, 3'd0, 3'd0, 1'b0, 8'd30, 8'd30},
        '{4'd3, 3'd0, 3'd0, 1'b1, 8'd31, 8'd34},
        '{4'd3, 3'd1, 3'd0, 1'b0, 8'd32, 8'd31},
        '{4'd3, 3'd0, 3'd0, 1'b0, 8'd33, 8'd35},
        '{4'd3, 3'd5, 3'd0, 1'b0, 8'd34, 8'd32},
        '{4'd3, 3'd5, 3'd0, 1'b1, 8'd35, 8'd36},
        '{4'd3, 3'd5, 3'd0, 1'b0, 8'd36, 8'd33},
        '{4'd3, 3'd5, 3'd0, 1'b0, 8'd37, 8'd37},
        '{4'd4, 3'd2, 3'd0, 1'b0, 8'd60, 8'd60},
        '{4'd4, 3'd3, 3'd0, 1'b0, 8'd61, 8'd62},
        '{4'd4, 3'd0, 3'd0, 1'b0, 8'd62, 8'd61}
    };

    // Requirement names for each table scenario.
    function automatic string scen_req(int s);
        case (s)
            0: return "R5";
            1: return "R5";
            2: return "R8";
            3: return "R6 R9";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Record each egress transfer, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && ngot < 64) begin
            got[ngot] = int'(out_tag);
            ngot++;
        end
    end

    // Drive one push for one cycle and report whether it was accepted.
    task automatic push(input int k, input int tc, input int ro, input int tag, output bit acc);
        in_kind = 3'(k); in_tc = TC_W'(tc); in_ro = ro[0]; in_tag = TAG_W'(tag);
        in_valid = 1'b1;
        @(negedge clk);
        acc = in_ready;
        if (acc) begin
            arr_no[tag] = npush; arr_kind[tag] = k; arr_tc[tag] = tc; arr_ro[tag] = ro;
            npush++;
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    task automatic drain(input int n);
        out_ready = 1'b1;
        for (int c = 0; c < 2 * n + 10; c++) begin
            @(posedge clk);
            if (ngot >= n) break;
        end
        #1 out_ready = 1'b0;
    endtask

    function automatic int qof(int k);
        if (k <= 1) return 0;
        if (k <= 3) return 1;
        return 2;
    endfunction

    // Pass-rule judgement for header a leaving before older header b.
    function automatic bit may_pass(int a, int b);
        int qa = qof(arr_kind[a]);
        int qb = qof(arr_kind[b]);
        if (arr_tc[a] != arr_tc[b]) return 1'b1;
        if (qa == qb) return 1'b0;
        if (qa == 0) return 1'b1;
        if (qb != 0) return 1'b1;
        if (qa == 1) return 1'b0;
        if (arr_kind[a] == 5) return 1'b1;
        return arr_ro[a] != 0;
    endfunction

    function automatic string pair_req(int a, int b);
        int qa = qof(arr_kind[a]);
        int qb = qof(arr_kind[b]);
        if (qa == qb) return (qa == 0) ? "R3" : "R2";
        if (qa == 1) return "R4";
        return "R5";
    endfunction

    // Judge every overtaking pair in the recorded egress order.
    task automatic pair_scan();
        for (int i = 0; i < ngot; i++)
            for (int j = i + 1; j < ngot; j++)
                if (arr_no[got[i]] > arr_no[got[j]])
                    chk(pair_req(got[i], got[j]), int'(may_pass(got[i], got[j])), 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        bit acc;
        int first;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        @(posedge clk); #1;

        first = 0;
        for (int r = 0; r < NV; r++) begin
            push(int'(TBL[r].kind), int'(TBL[r].tc), int'(TBL[r].ro), int'(TBL[r].tag), acc);
            chk("R10 table push accepted", int'(acc), 1);
            if (r == NV - 1 || TBL[r + 1].scen != TBL[r].scen) begin
                @(negedge clk);
                chk("R11 stalled offer is first header", int'(out_valid), 1);
                chk("R11 stalled offer is first header", int'(out_tag), int'(TBL[first].exp));
                @(posedge clk); #1;
                ngot = 0;
                drain(r - first + 1);
                chk({scen_req(int'(TBL[r].scen)), " count"}, ngot, r - first + 1);
                for (int k = 0; k < r - first + 1; k++)
                    chk(scen_req(int'(TBL[r].scen)), got[k], int'(TBL[first + k].exp));
                pair_scan();
                first = r + 1;
            end
        end

        // Fill the posted queue, try one more, then push a request.
        for (int i = 0; i < 8; i++) push(0, 0, 0, 40 + i, acc);
        in_kind = 3'd0; in_tc = '0; in_ro = 1'b0; in_tag = 8'd48; in_valid = 1'b1;
        @(negedge clk);
        chk("R10 ready low on full posted queue", int'(in_ready), 0);
        @(posedge clk); #1 in_valid = 1'b0;
        push(2, 0, 0, 49, acc);
        chk("R10 other queue accepts while posted full", int'(acc), 1);
        @(negedge clk);
        chk("R11 stalled offer unchanged", int'(out_tag), 40);
        @(posedge clk); #1;
        ngot = 0;
        drain(9);
        chk("R10 full drain count", ngot, 9);
        for (int k = 0; k < 8; k++) chk("R3 full drain order", got[k], 40 + k);
        chk("R4 request after all older posted", got[8], 49);
        pair_scan();

        // Push while the previous header transfers in the same cycle.
        ngot = 0;
        out_ready = 1'b1;
        push(1, 0, 0, 70, acc);
        push(0, 0, 0, 71, acc);
        chk("R12 push accepted during transfer", int'(acc), 1);
        repeat (3) @(posedge clk);
        #1 out_ready = 1'b0;
        chk("R12 transfers", ngot, 2);
        chk("R12 first out", got[0], 70);
        chk("R12 second out", got[1], 71);
        @(negedge clk);
        chk("R1 nothing offered when empty", int'(out_valid), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule